// File: doc/BRIEF.md
# Gated-Enable Full-Duplex UART

This block is an asynchronous serial transceiver with one serial output and one serial input. Both directions run at the same time. Each character is sent least significant bit first. A character is framed by a low start bit and a high stop bit, and it carries either 7 or 8 data bits. A 5-bit divider value sets the rate of an oversampling tick: one tick every `div+1` base clocks. Every bit lasts 16 ticks.

A host controls the block through plain register-style signals: a master power enable, a transmit enable request, a receive enable request, a data-length select and the divider value. Data moves through a write strobe with a data byte, and through a received-data byte with a valid flag that a read strobe clears. Busy flags report activity on each side.

The two enable requests are treated as asynchronous. They pass through two synchronizer flops before they act. Neither path can come on while the master power enable is low. Once a path has gone off, it stays off for a minimum gap before it can come on again. A transmit write is only accepted once the transmit path has been on for at least one full clock.

Top module: `uart_gated_xcvr`

## Requirements
- R1: The transmit line rests at 1 whenever no character is in flight. A frame is one 0 start bit, then the data bits least significant bit first, then one 1 stop bit.
- R2: With `len7`=1 a frame carries 7 data bits, `tx_data[7]` is not sent, and the received byte has bit 7 forced to 0. With `len7`=0 a frame carries 8 data bits.
- R3: Every bit on the transmit line lasts exactly 16*(`div`+1) base clocks.
- R4: Transmit and receive operate at the same time without disturbing each other.
- R5: While `pwr_en`=0, `tx_on` and `rx_on` are 0. One clock after `pwr_en` falls, any frame in flight is abandoned: `txd` is 1, `tx_busy` is 0 and `rx_valid` is 0.
- R6: An enable request that is raised while `pwr_en`=1 (and outside a gap) shows on `tx_on`/`rx_on` on the third rising clock edge after it is sampled.
- R7: Once `tx_on` or `rx_on` falls, it stays 0 for at least two base clocks. A request that is present during that gap is held off, and it takes effect when the gap ends.
- R8: A `tx_wr` pulse starts a frame only if `tx_on` was already 1 on the previous clock and `tx_busy` is 0. Any other `tx_wr` is ignored, and no frame follows from it.
- R9: The receiver starts on a falling edge of the synchronized input and checks the start bit again at mid-bit. A low pulse shorter than half a bit is rejected, leaves `rx_valid` at 0, and leaves the receiver idle.
- R10: A frame whose stop sample is 0 still sets `rx_valid`, and it sets `frame_err` to 1. A frame with a good stop bit sets `frame_err` to 0.
- R11: `rx_valid` rises when a frame completes. A `rx_rd` pulse clears it on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Master power enable |
| tx_en_req | input | 1 | Transmit enable request (asynchronous) |
| rx_en_req | input | 1 | Receive enable request (asynchronous) |
| len7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| div | input | DIV_W | Oversampling tick divider, one tick per div+1 clocks |
| tx_wr | input | 1 | Transmit data write strobe |
| tx_data | input | 8 | Transmit data byte |
| tx_on | output | 1 | Transmit path effectively enabled |
| tx_busy | output | 1 | A character is being sent |
| txd | output | 1 | Serial data output |
| rxd | input | 1 | Serial data input (asynchronous) |
| rx_rd | input | 1 | Received data read strobe |
| rx_on | output | 1 | Receive path effectively enabled |
| rx_busy | output | 1 | Receiver is inside a frame |
| rx_data | output | 8 | Last received character |
| rx_valid | output | 1 | Unread character available |
| frame_err | output | 1 | Stop bit of the last frame sampled as 0 |

## Verification
On every cycle the assertions check the enable rules: neither path is on without power, the gap is respected after a path turns off, and an enable only rises after the synchronized request has arrived. They also check that the line sits high whenever nothing is being sent, and that a frame only starts after the transmit path has been on for a clock. The serial content itself can only be shown by the bench's scenarios: bit order, the 7/8-bit choice, exact bit length for two divider values, concurrent traffic in both directions, rejection of a short glitch, framing errors, and ignored early or overlapping writes.

// File: rtl/uart_gated_xcvr.sv
module uart_gated_xcvr #(
  parameter int DIV_W    = 5,
  parameter int GAP_CLKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_en,
  input  logic             tx_en_req,
  input  logic             rx_en_req,
  input  logic             len7,
  input  logic [DIV_W-1:0] div,
  input  logic             tx_wr,
  input  logic [7:0]       tx_data,
  output logic             tx_on,
  output logic             tx_busy,
  output logic             txd,
  input  logic             rxd,
  input  logic             rx_rd,
  output logic             rx_on,
  output logic             rx_busy,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             frame_err
);
  localparam int GAP_W = $clog2(GAP_CLKS + 1);
  localparam logic [3:0] PH_LAST = 4'hF;
  localparam logic [3:0] PH_MID  = 4'h7;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_t;

  // enable synchronizers and gap control
  logic [1:0] txe_s, rxe_s, rxd_s;
  logic [GAP_W-1:0] tx_gap, rx_gap;
  logic tx_on_d;

  wire tx_on_nx = pwr_en & txe_s[1] & (tx_on | (tx_gap == '0));
  wire rx_on_nx = pwr_en & rxe_s[1] & (rx_on | (rx_gap == '0));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      txe_s   <= '0;
      rxe_s   <= '0;
      rxd_s   <= 2'b11;
      tx_on   <= 1'b0;
      rx_on   <= 1'b0;
      tx_on_d <= 1'b0;
      tx_gap  <= '0;
      rx_gap  <= '0;
    end else begin
      txe_s   <= {txe_s[0], tx_en_req};
      rxe_s   <= {rxe_s[0], rx_en_req};
      rxd_s   <= {rxd_s[0], rxd};
      tx_on   <= tx_on_nx;
      rx_on   <= rx_on_nx;
      tx_on_d <= tx_on;
      if (tx_on && !tx_on_nx)  tx_gap <= GAP_W'(GAP_CLKS);
      else if (tx_gap != '0)   tx_gap <= tx_gap - 1'b1;
      if (rx_on && !rx_on_nx)  rx_gap <= GAP_W'(GAP_CLKS);
      else if (rx_gap != '0)   rx_gap <= rx_gap - 1'b1;
    end

  // transmitter
  logic [9:0]       tx_sh;
  logic [DIV_W-1:0] tx_dc;
  logic [3:0]       tx_ph, tx_bc;
  logic             tx_l7;

  wire tx_tick = (tx_dc == div);
  wire tx_bend = tx_tick & (tx_ph == PH_LAST);
  wire tx_load = tx_wr & tx_on & tx_on_d & ~tx_busy;
  wire [3:0] tx_last = tx_l7 ? 4'd8 : 4'd9;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_sh <= '1; tx_dc <= '0; tx_ph <= '0; tx_bc <= '0;
      tx_busy <= 1'b0; tx_l7 <= 1'b0;
    end else if (!tx_on_nx) begin
      tx_sh <= '1; tx_dc <= '0; tx_ph <= '0; tx_bc <= '0;
      tx_busy <= 1'b0;
    end else if (tx_load) begin
      tx_sh   <= {1'b1, len7 | tx_data[7], tx_data[6:0], 1'b0};
      tx_l7   <= len7;
      tx_dc   <= '0; tx_ph <= '0; tx_bc <= '0;
      tx_busy <= 1'b1;
    end else if (tx_busy) begin
      tx_dc <= tx_tick ? '0 : tx_dc + 1'b1;
      if (tx_tick) tx_ph <= tx_ph + 1'b1;
      if (tx_bend) begin
        tx_sh <= {1'b1, tx_sh[9:1]};
        tx_bc <= tx_bc + 1'b1;
        if (tx_bc == tx_last) tx_busy <= 1'b0;
      end
    end

  assign txd = tx_sh[0];

  // receiver
  rx_st_t           rx_st;
  logic [DIV_W-1:0] rx_dc;
  logic [3:0]       rx_ph;
  logic [2:0]       rx_bc;
  logic [7:0]       rx_sh;
  logic             rx_l7, rxs_q;

  wire rxs     = rxd_s[1];
  wire rx_tick = (rx_dc == div);
  wire rx_bend = rx_tick & (rx_ph == PH_LAST);
  wire rx_done = rx_on_nx & (rx_st == RX_STOP) & rx_bend;

  assign rx_busy = (rx_st != RX_IDLE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_st <= RX_IDLE; rx_dc <= '0; rx_ph <= '0; rx_bc <= '0;
      rx_sh <= '0; rx_l7 <= 1'b0; rxs_q <= 1'b1;
      rx_data <= '0; frame_err <= 1'b0; rx_valid <= 1'b0;
    end else begin
      rxs_q <= rxs;
      if (!rx_on_nx) begin
        rx_st <= RX_IDLE;
      end else if (rx_st == RX_IDLE) begin
        if (rxs_q && !rxs) begin
          rx_st <= RX_START; rx_dc <= '0; rx_ph <= '0; rx_l7 <= len7;
        end
      end else begin
        rx_dc <= rx_tick ? '0 : rx_dc + 1'b1;
        if (rx_tick) rx_ph <= rx_ph + 1'b1;
        case (rx_st)
          RX_START:
            if (rx_tick && rx_ph == PH_MID) begin
              rx_ph <= '0;
              rx_bc <= '0;
              rx_st <= rxs ? RX_IDLE : RX_DATA;
            end
          RX_DATA:
            if (rx_bend) begin
              rx_sh <= {rxs, rx_sh[7:1]};
              rx_bc <= rx_bc + 1'b1;
              if (rx_bc == (rx_l7 ? 3'd6 : 3'd7)) rx_st <= RX_STOP;
            end
          default:
            if (rx_bend) rx_st <= RX_IDLE;
        endcase
      end
      if (rx_done) begin
        rx_data   <= rx_l7 ? {1'b0, rx_sh[7:1]} : rx_sh;
        frame_err <= ~rxs;
      end
      if (!pwr_en)       rx_valid <= 1'b0;
      else if (rx_done)  rx_valid <= 1'b1;
      else if (rx_rd)    rx_valid <= 1'b0;
    end

  // assertions
  AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !tx_busy |-> txd); // R1
  AST_PWR_OFF_PATHS: assert property (@(posedge clk) disable iff (!rst_n) !pwr_en |=> !tx_on && !rx_on); // R5
  AST_PWR_OFF_ABORT: assert property (@(posedge clk) disable iff (!rst_n) !pwr_en |=> txd && !tx_busy && !rx_valid); // R5
  AST_TX_SYNC_LAT: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_on) |-> $past(tx_en_req, 3)); // R6
  AST_RX_SYNC_LAT: assert property (@(posedge clk) disable iff (!rst_n) $rose(rx_on) |-> $past(rx_en_req, 3)); // R6
  AST_TX_GAP: assert property (@(posedge clk) disable iff (!rst_n) $fell(tx_on) |=> !tx_on ##1 !tx_on); // R7
  AST_RX_GAP: assert property (@(posedge clk) disable iff (!rst_n) $fell(rx_on) |=> !rx_on ##1 !rx_on); // R7
  AST_TX_START_RDY: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_busy) |-> $past(tx_on) && $past(tx_on, 2)); // R8
  AST_BUSY_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n) tx_busy |-> tx_on); // R8
  AST_RXV_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n) $rose(rx_valid) |-> $past(rx_on) && $past(rx_busy)); // R11
endmodule

// File: tb/tb_uart_gated_xcvr.sv
module tb_uart_gated_xcvr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_en = 1'b0, tx_en_req = 1'b0, rx_en_req = 1'b0, len7 = 1'b0;
  logic [4:0] div = 5'd1;
  logic tx_wr = 1'b0, rx_rd = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_on, tx_busy, txd, rx_on, rx_busy, rx_valid, frame_err;
  logic [7:0] rx_data;
  logic loop = 1'b1, rxd_drv = 1'b1;
  wire rxd = loop ? txd : rxd_drv;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  uart_gated_xcvr dut (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .tx_en_req(tx_en_req),
    .rx_en_req(rx_en_req), .len7(len7), .div(div), .tx_wr(tx_wr),
    .tx_data(tx_data), .tx_on(tx_on), .tx_busy(tx_busy), .txd(txd),
    .rxd(rxd), .rx_rd(rx_rd), .rx_on(rx_on), .rx_busy(rx_busy),
    .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err)
  );

  // {len7, data}
  localparam logic [8:0] VEC [0:5] = '{9'h0A5, 9'h000, 9'h0FF, 9'h15A, 9'h1FF, 9'h081};

  function automatic int bit_clks();
    return 16 * (int'(div) + 1);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tx_write(input logic [7:0] d);
    @(negedge clk); tx_data = d; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic read_rx();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic grab_tx(input int n, output logic [9:0] bits);
    int t = 0;
    bits = '0;
    while (txd !== 1'b0 && t < 5000) begin @(negedge clk); t++; end
    repeat (bit_clks() / 2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      bits[i] = txd;
      repeat (bit_clks()) @(negedge clk);
    end
  endtask

  task automatic drive_rx(input logic [7:0] d, input int nd, input logic stopv);
    @(negedge clk); rxd_drv = 1'b0;
    repeat (bit_clks()) @(negedge clk);
    for (int i = 0; i < nd; i++) begin
      rxd_drv = d[i];
      repeat (bit_clks()) @(negedge clk);
    end
    rxd_drv = stopv;
    repeat (bit_clks()) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_rxv();
    int t = 0;
    while (rx_valid !== 1'b1 && t < 4 * bit_clks()) begin @(negedge clk); t++; end
  endtask

  function automatic logic [9:0] frame_of(input logic l7, input logic [7:0] d);
    return l7 ? {1'b0, 1'b1, d[6:0], 1'b0} : {1'b1, d, 1'b0};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [9:0] bits, bits2;
    logic [7:0] expd;
    int n, cnt;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state, R1
    check(txd === 1'b1 && tx_busy === 1'b0, "R1 reset line idle", {txd, tx_busy}, 2'b10);
    check(rx_valid === 1'b0 && tx_on === 1'b0 && rx_on === 1'b0, "R5 reset enables off", {rx_valid, tx_on, rx_on}, 3'b000);

    // R5: requests without power
    tx_en_req = 1'b1; rx_en_req = 1'b1;
    repeat (6) @(negedge clk);
    check(tx_on === 1'b0 && rx_on === 1'b0, "R5 no enable without power", {tx_on, rx_on}, 2'b00);
    tx_wr = 1'b1; tx_data = 8'h00;
    @(negedge clk); tx_wr = 1'b0;
    repeat (3) @(negedge clk);
    check(tx_busy === 1'b0 && txd === 1'b1, "R5 write ignored without power", {tx_busy, txd}, 2'b01);

    // R6: sync latency, R8: early write ignored
    tx_en_req = 1'b0; rx_en_req = 1'b0; pwr_en = 1'b1;
    repeat (5) @(negedge clk);
    tx_en_req = 1'b1; rx_en_req = 1'b1;
    @(negedge clk); @(negedge clk);
    check(tx_on === 1'b0, "R6 tx_on before third edge", tx_on, 1'b0);
    @(negedge clk);
    check(tx_on === 1'b1 && rx_on === 1'b1, "R6 enables on third edge", {tx_on, rx_on}, 2'b11);
    tx_data = 8'h00; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
    repeat (bit_clks()) @(negedge clk);
    check(tx_busy === 1'b0 && txd === 1'b1, "R8 write in first enabled clock ignored", {tx_busy, txd}, 2'b01);

    // R7: short drop of the request is stretched to the gap
    tx_en_req = 1'b0;
    @(negedge clk); tx_en_req = 1'b1;
    cnt = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (tx_on === 1'b0) cnt++; end
    check(cnt >= 2, "R7 off time after clear", cnt, 2);
    check(tx_on === 1'b1, "R7 held request honoured after gap", tx_on, 1'b1);
    repeat (4) @(negedge clk);

    // vector table in loopback: R1, R2, R11, R10
    foreach (VEC[k]) begin
      len7 = VEC[k][8];
      n = len7 ? 9 : 10;
      expd = len7 ? {1'b0, VEC[k][6:0]} : VEC[k][7:0];
      tx_write(VEC[k][7:0]);
      grab_tx(n, bits);
      check(bits === frame_of(len7, VEC[k][7:0]), len7 ? "R2 7-bit frame on line" : "R1 8-bit frame on line",
            bits, frame_of(len7, VEC[k][7:0]));
      wait_rxv();
      check(rx_valid === 1'b1 && rx_data === expd, "R2 loopback data", rx_data, expd);
      check(frame_err === 1'b0, "R10 good stop bit", frame_err, 1'b0);
      read_rx();
      check(rx_valid === 1'b0, "R11 read clears valid", rx_valid, 1'b0);
    end
    len7 = 1'b0;

    // R3: bit length for two divider values
    for (int dv = 1; dv <= 3; dv += 2) begin
      div = 5'(dv);
      repeat (4) @(negedge clk);
      tx_write(8'h01);
      while (txd !== 1'b0) @(negedge clk);
      cnt = 0;
      while (txd === 1'b0 && cnt < 1000) begin @(negedge clk); cnt++; end
      check(cnt == 16 * (dv + 1), "R3 start bit length", cnt, 16 * (dv + 1));
      while (tx_busy === 1'b1) @(negedge clk);
      wait_rxv(); read_rx();
    end
    div = 5'd1;
    repeat (4) @(negedge clk);

    // R8: write while busy ignored
    tx_write(8'h0F);
    repeat (40) @(negedge clk);
    tx_write(8'hF0);
    while (tx_busy === 1'b1) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 2 * bit_clks(); i++) begin @(negedge clk); if (txd === 1'b0) cnt++; end
    check(cnt == 0, "R8 write while busy starts no frame", cnt, 0);
    check(rx_data === 8'h0F, "R8 only first byte sent", rx_data, 8'h0F);
    read_rx();

    // R9: glitch rejection, then a clean frame
    loop = 1'b0;
    @(negedge clk); rxd_drv = 1'b0;
    repeat (4) @(negedge clk); rxd_drv = 1'b1;
    repeat (2 * bit_clks()) @(negedge clk);
    check(rx_busy === 1'b0 && rx_valid === 1'b0, "R9 glitch rejected", {rx_busy, rx_valid}, 2'b00);
    drive_rx(8'h96, 8, 1'b1);
    wait_rxv();
    check(rx_valid === 1'b1 && rx_data === 8'h96, "R9 frame after glitch", rx_data, 8'h96);
    read_rx();

    // R10: bad stop bit
    drive_rx(8'h3C, 8, 1'b0);
    wait_rxv();
    check(rx_valid === 1'b1 && frame_err === 1'b1, "R10 framing error flagged", {rx_valid, frame_err}, 2'b11);
    check(rx_data === 8'h3C, "R10 data kept with error", rx_data, 8'h3C);
    read_rx();

    // R4: full duplex
    fork
      begin tx_write(8'h3C); grab_tx(10, bits2); end
      drive_rx(8'hC5, 8, 1'b1);
    join
    wait_rxv();
    check(bits2 === frame_of(1'b0, 8'h3C), "R4 tx frame during rx", bits2, frame_of(1'b0, 8'h3C));
    check(rx_data === 8'hC5 && frame_err === 1'b0, "R4 rx data during tx", rx_data, 8'hC5);

    // R5: power drop mid-frame, rx_valid still set from R4
    tx_write(8'h00);
    repeat (40) @(negedge clk);
    pwr_en = 1'b0;
    @(negedge clk);
    check(txd === 1'b1 && tx_busy === 1'b0, "R5 power drop aborts tx", {txd, tx_busy}, 2'b10);
    check(rx_valid === 1'b0 && tx_on === 1'b0 && rx_on === 1'b0, "R5 power drop clears state",
          {rx_valid, tx_on, rx_on}, 3'b000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule